// File: doc/BRIEF.md
# Dual-Channel Serial ADC Sequencer

This block controls a simultaneous-sampling serial converter with two channels. It divides the system clock down to a serial clock and runs fixed conversion frames of 32 serial clocks each. It pulses a conversion-start strobe at the start of every frame. It drives the converter's mode-select and channel-address pins and keeps the converter's chip select asserted.

During the first half of a frame the address line is high and the returned bits belong to channel 1. After 16 serial clocks the address line goes low and the second half returns channel 0. Each half-frame's 16 bits are shifted in MSB first. At the end of each half, a parallel word is presented with a one-cycle valid pulse and a channel tag.

Frames repeat back to back while the enable input is high. When enable drops, the frame in progress is finished before the sequencer goes idle.

Top module: `adc_pair_sequencer`

## Requirements
- R1: `adc_csn` is 0 at all times, and the mode pins are fixed at `mode_sel0` = 0 and `mode_sel1` = 1.
- R2: `sclk` is a square wave with each level lasting `SCLK_HALF` system clocks. It is low during reset.
- R3: A frame is exactly 32 serial clocks long. `convst` goes high at the falling `sclk` edge that starts a frame and stays high for one serial period. When frames run back to back, successive `convst` rises are 64*`SCLK_HALF` system clocks apart.
- R4: `chan_addr` is 1 for the first 16 serial clocks of a frame. It is 0 for the last 16, which is 16 serial periods. It is 1 while idle.
- R5: Bits are sampled from `sdata_in` at rising `sclk` edges and assembled MSB first. At the end of each 16-bit half-frame, `sample_out` takes the word and `sample_valid` pulses for one system clock.
- R6: `sample_chan` is 1 for the word from the first half-frame and 0 for the word from the second half-frame.
- R7: `convst` and `chan_addr` change only when `sclk` falls. `sample_valid` rises only when `sclk` rises.
- R8: Synchronous active-high `rst` clears the outputs to `convst` = 0, `sample_valid` = 0, `chan_addr` = 1 and `sclk` = 0. With `enable` low, no frame starts and `convst` stays low.
- R9: If `enable` is deasserted during a frame, that frame completes and delivers both words. The sequencer then goes idle with no further `convst` pulses or samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows frames to start |
| sdata_in | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock to the converter |
| convst | output | 1 | Conversion-start strobe |
| chan_addr | output | 1 | Channel-address line (1 = channel 1) |
| mode_sel0 | output | 1 | Mode-select pin 0, tied 0 |
| mode_sel1 | output | 1 | Mode-select pin 1, tied 1 |
| adc_csn | output | 1 | Converter chip select, active low, held 0 |
| sample_out | output | SAMPLE_W | Last assembled sample |
| sample_valid | output | 1 | One-cycle pulse when `sample_out` is updated |
| sample_chan | output | 1 | Channel of `sample_out` (1 or 0) |

## Verification
The assertions assume that `rst` is held for at least one system clock. They also assume that `sdata_in` is stable around every rising `sclk` edge, as a real converter guarantees by changing its output after the falling edge. The bench plays the converter: it changes `sdata_in` only at system-clock negative edges that follow a falling `sclk`, so it never moves the line near a sampling point. `enable` is toggled at arbitrary points, including mid-frame, because the design must tolerate it changing at any time.

// File: rtl/adc_pair_sequencer.sv
module adc_pair_sequencer #(
  parameter int SCLK_HALF = 4,
  parameter int SAMPLE_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                sdata_in,
  output logic                sclk,
  output logic                convst,
  output logic                chan_addr,
  output logic                mode_sel0,
  output logic                mode_sel1,
  output logic                adc_csn,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic                sample_valid,
  output logic                sample_chan
);
  localparam int FRAME_CLKS = 2 * SAMPLE_W;
  localparam int BIT_W      = $clog2(FRAME_CLKS);
  localparam int DIV_W      = $clog2(SCLK_HALF + 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_CLKS - 1);
  localparam logic [BIT_W-1:0] HALF_LAST = BIT_W'(SAMPLE_W - 1);

  logic [DIV_W-1:0]    div_cnt;
  logic [BIT_W-1:0]    bit_cnt;
  logic [SAMPLE_W-1:0] shreg;
  logic                busy;
  logic                tick, rise_tick, fall_tick, half_done;

  assign adc_csn   = 1'b0;
  assign mode_sel0 = 1'b0;
  assign mode_sel1 = 1'b1;

  assign tick      = (div_cnt == DIV_W'(SCLK_HALF - 1));
  assign rise_tick = tick & ~sclk;
  assign fall_tick = tick & sclk;
  assign half_done = (bit_cnt[BIT_W-2:0] == HALF_LAST[BIT_W-2:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      sclk    <= 1'b0;
    end else if (tick) begin
      div_cnt <= '0;
      sclk    <= ~sclk;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      bit_cnt   <= '0;
      convst    <= 1'b0;
      chan_addr <= 1'b1;
    end else if (fall_tick) begin
      if (busy && bit_cnt != LAST_BIT) begin
        bit_cnt   <= bit_cnt + 1'b1;
        convst    <= 1'b0;
        chan_addr <= (bit_cnt < HALF_LAST);
      end else if (enable) begin
        busy      <= 1'b1;
        bit_cnt   <= '0;
        convst    <= 1'b1;
        chan_addr <= 1'b1;
      end else begin
        busy      <= 1'b0;
        bit_cnt   <= '0;
        convst    <= 1'b0;
        chan_addr <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg        <= '0;
      sample_out   <= '0;
      sample_valid <= 1'b0;
      sample_chan  <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      if (rise_tick && busy) begin
        shreg <= {shreg[SAMPLE_W-2:0], sdata_in};
        if (half_done) begin
          sample_out   <= {shreg[SAMPLE_W-2:0], sdata_in};
          sample_valid <= 1'b1;
          sample_chan  <= ~bit_cnt[BIT_W-1];
        end
      end
    end
  end

  p_ctrl_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(convst) || !$stable(chan_addr)) |-> $fell(sclk));
  p_valid_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_valid) |-> $rose(sclk));
  p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);
  p_convst_in_first_half_r4: assert property (@(posedge clk) disable iff (rst)
    convst |-> chan_addr);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!convst && chan_addr));
  p_sclk_level_r2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sclk)) |=> $stable(sclk));
endmodule

// File: tb/adc_pair_sequencer_bench.sv
module adc_pair_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int W = 16;

  logic clk = 0, rst = 1, enable = 0, sdata_in = 0;
  logic sclk, convst, chan_addr, mode_sel0, mode_sel1, adc_csn, sample_valid, sample_chan;
  logic [W-1:0] sample_out;

  adc_pair_sequencer #(.SCLK_HALF(HALF), .SAMPLE_W(W)) u_adc_pair_sequencer (
    .clk(clk), .rst(rst), .enable(enable), .sdata_in(sdata_in), .sclk(sclk),
    .convst(convst), .chan_addr(chan_addr), .mode_sel0(mode_sel0), .mode_sel1(mode_sel1),
    .adc_csn(adc_csn), .sample_out(sample_out), .sample_valid(sample_valid),
    .sample_chan(sample_chan));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [W-1:0] w1 [8];
  logic [W-1:0] w0 [8];
  logic [W-1:0] cap_d [32];
  logic         cap_c [32];
  int n_cap = 0, n_conv = 0, frame = -1, k = 0;
  int conv_len = 0, conv_run = 0, addr_run = 0, addr_lo_len = 0;
  int sclk_run = 0, sclk_hi_len = 0, cyc = 0, last_rise = 0, gap = 0;
  int pin_bad = 0;
  logic prev_sclk = 0, prev_conv = 0, prev_addr = 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      prev_sclk = sclk; prev_conv = convst; prev_addr = chan_addr;
    end else begin
      if (adc_csn !== 1'b0 || mode_sel0 !== 1'b0 || mode_sel1 !== 1'b1) pin_bad++;
      if (prev_sclk && !sclk) begin
        if (convst) begin k = 0; frame++; end
        else k++;
        if (frame >= 0)
          sdata_in = (k < W) ? w1[frame % 8][W-1-k] : w0[frame % 8][2*W-1-k];
      end
      if (sclk) sclk_run++;
      else if (prev_sclk) begin sclk_hi_len = sclk_run; sclk_run = 0; end
      if (convst && !prev_conv) begin
        n_conv++; gap = cyc - last_rise; last_rise = cyc; conv_run = 0;
      end
      if (convst) conv_run++;
      else if (prev_conv) conv_len = conv_run;
      if (!chan_addr) addr_run++;
      else if (!prev_addr) begin addr_lo_len = addr_run; addr_run = 0; end
      if (sample_valid && n_cap < 32) begin
        cap_d[n_cap] = sample_out; cap_c[n_cap] = sample_chan; n_cap++;
      end
      prev_sclk = sclk; prev_conv = convst; prev_addr = chan_addr;
    end
  end

  task automatic do_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(convst == 0, "R8 convst in reset", convst, 0);
    chk(sample_valid == 0, "R8 valid in reset", sample_valid, 0);
    chk(chan_addr == 1, "R8 addr in reset", chan_addr, 1);
    chk(sclk == 0, "R2/R8 sclk in reset", sclk, 0);
    rst = 0;
  endtask

  task automatic test_idle();
    int c0;
    c0 = n_conv;
    repeat (300) @(negedge clk);
    chk(n_conv == c0, "R8 no frame without enable", n_conv, c0);
    chk(n_cap == 0, "R8 no samples idle", n_cap, 0);
    chk(adc_csn == 0 && mode_sel0 == 0 && mode_sel1 == 1, "R1 fixed pins",
        {adc_csn, mode_sel0, mode_sel1}, 3'b001);
    chk(sclk_hi_len == HALF, "R2 sclk level length", sclk_hi_len, HALF);
  endtask

  task automatic test_single_frame();
    int c0, s0;
    c0 = n_conv; s0 = n_cap;
    @(negedge clk) enable = 1;
    wait (n_conv == c0 + 1);
    repeat (20) @(negedge clk);
    enable = 0;
    repeat (64 * HALF + 200) @(negedge clk);
    chk(n_conv == c0 + 1, "R9 single convst after disable", n_conv, c0 + 1);
    chk(n_cap == s0 + 2, "R9 frame completes two words", n_cap, s0 + 2);
    chk(cap_d[s0] == w1[frame % 8], "R5 ch1 word MSB first", cap_d[s0], w1[frame % 8]);
    chk(cap_c[s0] == 1, "R6 first word tag", cap_c[s0], 1);
    chk(cap_d[s0+1] == w0[frame % 8], "R5 ch0 word", cap_d[s0+1], w0[frame % 8]);
    chk(cap_c[s0+1] == 0, "R6 second word tag", cap_c[s0+1], 0);
    chk(conv_len == 2 * HALF, "R3 convst one serial period", conv_len, 2 * HALF);
    chk(addr_lo_len == 16 * 2 * HALF, "R4 addr low 16 serial clocks", addr_lo_len, 32 * HALF);
    chk(convst == 0 && chan_addr == 1, "R8 idle after frame", {convst, chan_addr}, 2'b01);
  endtask

  task automatic test_back_to_back();
    int c0, s0, f0;
    c0 = n_conv; s0 = n_cap;
    @(negedge clk) enable = 1;
    wait (n_conv == c0 + 3);
    f0 = frame - 2;
    chk(gap == 64 * HALF, "R3 frame period 32 serial clocks", gap, 64 * HALF);
    repeat (5) @(negedge clk);
    enable = 0;
    repeat (64 * HALF + 200) @(negedge clk);
    chk(n_conv == c0 + 3, "R9 stops after current frame", n_conv, c0 + 3);
    chk(n_cap == s0 + 6, "R5 six words in three frames", n_cap, s0 + 6);
    for (int i = 0; i < 3; i++) begin
      chk(cap_d[s0+2*i] == w1[(f0+i) % 8] && cap_c[s0+2*i] == 1, "R5/R6 ch1 word in stream",
          cap_d[s0+2*i], w1[(f0+i) % 8]);
      chk(cap_d[s0+2*i+1] == w0[(f0+i) % 8] && cap_c[s0+2*i+1] == 0, "R5/R6 ch0 word in stream",
          cap_d[s0+2*i+1], w0[(f0+i) % 8]);
    end
  endtask

  task automatic test_reset_midframe();
    int s0;
    @(negedge clk) enable = 1;
    repeat (40 * HALF) @(negedge clk);
    s0 = n_cap;
    do_reset();
    enable = 0;
    repeat (200) @(negedge clk);
    chk(n_cap == s0, "R8 reset aborts frame", n_cap, s0);
    chk(convst == 0 && chan_addr == 1, "R8 idle after reset", {convst, chan_addr}, 2'b01);
    chk(pin_bad == 0, "R1 pins never moved", pin_bad, 0);
  endtask

  initial begin
    w1[0] = 16'hA5C3; w0[0] = 16'h0F1E;
    w1[1] = 16'h8001; w0[1] = 16'h7FFE;
    w1[2] = 16'hFFFF; w0[2] = 16'h0000;
    w1[3] = 16'h1234; w0[3] = 16'hFEDC;
    w1[4] = 16'h5555; w0[4] = 16'hAAAA;
    w1[5] = 16'h0001; w0[5] = 16'h8000;
    w1[6] = 16'hC0DE; w0[6] = 16'hBEEF;
    w1[7] = 16'h3C3C; w0[7] = 16'hE71A;
    do_reset();
    test_idle();
    test_single_frame();
    test_back_to_back();
    test_reset_midframe();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule